// File: doc/BRIEF.md
# External Bus Cycle Controller

This block converts internal access requests into cycles on a 16-bit external system bus. A request holds an address, two byte enables, a read/write flag, a memory/I/O flag, an interrupt-acknowledge flag with a 3-bit cascade code, and a flag telling the block that the addressed region must run at 16-bit width. The block presents the address and a high-byte enable, drives one of four active-low command strobes and moves data on a split-direction 16-bit data bus. It ends the cycle with a one-clock done pulse that also carries read data.

The bus width is decided per cycle. An active-low width feedback line is sampled in the address phase. A device that leaves the line high is treated as 8 bits wide, and a word request to it becomes two byte cycles, with the odd byte carried on the low lanes. A ready input stretches the command phase by one clock for each clock it is seen low. Interrupt-acknowledge cycles put the cascade code on the top three address lines and pulse no command strobe. During reset the block keeps the levels read back from the address-bit-0 and high-byte-enable pins. These select the boot ROM width and a test mode in which the block floats its bus outputs and accepts no requests.

Every cycle has one address clock, then a command phase of one clock or more, then one end clock. Read data is captured on the clock edge that ends the command phase.

Top module: `xbus_cycle_ctrl`

## Requirements
- R1: An I/O read drives only `ior_n_o` low, an I/O write only `iow_n_o`, a memory read only `memr_n_o` and a memory write only `memw_n_o`. A strobe is low only during the command phase, and all other strobes stay high.
- R2: `bus_bhe_n_o` is low in every bus cycle of a request whose high-byte enable `req_be_i[1]` is set, and high in every cycle of a request whose high-byte enable is clear.
- R3: For an 8-bit device, a request with `req_be_i`=2'b11 runs two cycles: address bit 0 = 0 first, then address bit 0 = 1. In any cycle that moves only the odd byte, write data carries `req_wdata_i[15:8]` on both lanes, and a read from an 8-bit device takes lanes 7:0 into `rdata_o[15:8]`.
- R4: When `cs16_n_i` is low in the address phase, the request runs as one cycle, and both lanes are used as the byte enables select.
- R5: With `req_force16_i` set, the request runs as one 16-bit cycle whatever `cs16_n_i` does. `cs16_oe_o` is high, with `cs16_n_o` low, from the address phase through the end phase.
- R6: A command strobe stays low for 1 + N clocks, where N is the number of clocks in which `rdy_i` was sampled low during that command phase.
- R7: In an interrupt-acknowledge cycle, `req_cascade_i` appears on address bits 25:23, with code bit 2 on line 25 and code bit 0 on line 23. No command strobe goes low.
- R8: `boot16_o` holds the level of `strap_bhe_i` (1 = 16-bit boot ROM) and `test_mode_o` holds the inverse of `strap_a0_i` (0 selects test mode), both as they stood in the last clock of reset. Neither changes until the next reset.
- R9: In test mode, `bus_addr_oe_o`, `bus_data_oe_o` and `req_ready_o` are low, and no request is accepted or completed.
- R10: `bus_data_oe_o` is high only while a write request is between its first address phase and its last end phase. It is low whenever `req_ready_o` is high.
- R11: `done_o` pulses for one clock in the end phase of a request's last cycle. With `done_o`, `rdata_o` holds the enabled bytes (`req_be_i[0]` = even byte, lanes 7:0; `req_be_i[1]` = odd byte, lanes 15:8), and the bytes that are not enabled read as zero. `req_addr_i[0]` is ignored, and `req_be_i` must not be zero.
- R12: `req_ready_o` is high only while the block is idle. A request is taken on a clock edge where `req_valid_i` and `req_ready_o` are both high, and its first address phase follows in the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Block idle and able to take a request |
| req_addr_i | input | 26 | Request byte address (bit 0 ignored) |
| req_be_i | input | 2 | Byte enables: bit 0 even byte, bit 1 odd byte |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_io_i | input | 1 | 1 = I/O space, 0 = memory space |
| req_inta_i | input | 1 | Interrupt-acknowledge cycle |
| req_cascade_i | input | 3 | Cascade code for interrupt acknowledge |
| req_force16_i | input | 1 | Region is forced to 16-bit width |
| req_wdata_i | input | 16 | Write data |
| done_o | output | 1 | One-clock completion pulse |
| rdata_o | output | 16 | Read data, valid with done |
| bus_addr_o | output | 26 | Latched bus address |
| bus_addr_oe_o | output | 1 | Enable for address, high-byte enable and strobes |
| bus_bhe_n_o | output | 1 | High-byte enable, active low |
| bus_data_o | output | 16 | Data bus, outgoing value |
| bus_data_i | input | 16 | Data bus, incoming value |
| bus_data_oe_o | output | 1 | Data bus output enable |
| ior_n_o | output | 1 | I/O read strobe, active low |
| iow_n_o | output | 1 | I/O write strobe, active low |
| memr_n_o | output | 1 | Memory read strobe, active low |
| memw_n_o | output | 1 | Memory write strobe, active low |
| cs16_n_i | input | 1 | 16-bit device feedback, active low |
| cs16_n_o | output | 1 | Value driven on the feedback line (always low) |
| cs16_oe_o | output | 1 | Drive enable for the feedback line |
| rdy_i | input | 1 | Ready; low adds wait states |
| strap_a0_i | input | 1 | Address bit 0 pin readback for the mode strap |
| strap_bhe_i | input | 1 | High-byte-enable pin readback for the boot-width strap |
| boot16_o | output | 1 | Latched boot ROM width, 1 = 16-bit |
| test_mode_o | output | 1 | Latched test tri-state mode |

## Verification
The bench uses the default parameters: a 26-bit address and a 3-bit cascade code, so the cascade field lands on lines 25:23 and its bit order can be checked directly. The device model in the bench is switched between byte-wide and word-wide, can be set to pull or release the width feedback, and inserts zero, two or three wait clocks. This covers both split orders, odd-byte lane steering, forced width and stretched strobes. Two resets with opposite strap levels cover both boot widths and both run modes.

// File: rtl/xbus_pkg.sv
// Shared types for the external bus cycle controller.
// Assumes one outstanding request at a time.
package xbus_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_CMD,
        ST_WAIT,
        ST_END
    } cyc_state_t;

    localparam int unsigned NUM_STB = 4;

    // Strobe index: 0 io read, 1 io write, 2 mem read, 3 mem write.
    function automatic logic [1:0] stb_index(input logic io, input logic wr);
        return {~io, wr};
    endfunction

endpackage

// File: rtl/xbus_strap.sv
// Boot-strap latch: follows the strap pins while reset is held and keeps
// the last value seen once reset is released.
// Assumes the pins are stable during the final clock of reset.
module xbus_strap (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_a0_i,
    input  logic pin_bhe_i,
    output logic boot16_o,
    output logic test_mode_o
);

    // Track the strap pins during reset and hold them afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            boot16_o    <= pin_bhe_i;
            test_mode_o <= ~pin_a0_i;
        end
    end

    a_r8_strap_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ($stable(boot16_o) && $stable(test_mode_o)));

endmodule

// File: rtl/xbus_seq.sv
// Cycle sequencer: walks idle, address, command, wait and end phases,
// samples the width feedback, and decides whether a word must be split.
// Assumes the byte enables are held steady by the lane unit for the
// whole request.
module xbus_seq
    import xbus_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid_i,
    input  logic       test_mode_i,
    input  logic       cs16_n_i,
    input  logic       force16_i,
    input  logic [1:0] be_i,
    input  logic       rdy_i,
    output cyc_state_t state_o,
    output logic       phase_o,
    output logic       wide_o,
    output logic       req_ready_o,
    output logic       accept_o,
    output logic       capture_o,
    output logic       done_o
);

    cyc_state_t state_q, state_d;
    logic       phase_q;
    logic       wide_q;
    logic       split;
    logic       last;

    assign req_ready_o = (state_q == ST_IDLE) && !test_mode_i;
    assign accept_o    = req_ready_o && req_valid_i;
    assign split       = !wide_q && (be_i == 2'b11);
    assign last        = phase_q || !split;
    assign capture_o   = ((state_q == ST_CMD) || (state_q == ST_WAIT)) && rdy_i;
    assign done_o      = (state_q == ST_END) && last;
    assign state_o     = state_q;
    assign phase_o     = phase_q;
    assign wide_o      = wide_q;

    // Next-phase selection.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:         if (accept_o) state_d = ST_ADDR;
            ST_ADDR:         state_d = ST_CMD;
            ST_CMD, ST_WAIT: state_d = rdy_i ? ST_END : ST_WAIT;
            ST_END:          state_d = last ? ST_IDLE : ST_ADDR;
            default:         state_d = ST_IDLE;
        endcase
    end

    // Phase register, split half marker and width sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            phase_q <= 1'b0;
            wide_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept_o)
                phase_q <= 1'b0;
            else if ((state_q == ST_END) && !last)
                phase_q <= 1'b1;
            if (state_q == ST_ADDR)
                wide_q <= !cs16_n_i || force16_i;
        end
    end

    a_r6_wait_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (((state_q == ST_CMD) || (state_q == ST_WAIT)) && !rdy_i) |=> (state_q == ST_WAIT));

    a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r12_accept_to_addr: assert property (@(posedge clk) disable iff (!rst_n)
        accept_o |=> (state_q == ST_ADDR));

endmodule

// File: rtl/xbus_lanes.sv
// Request holding and byte-lane steering: latches the request, forms the
// cycle address (cascade overlay included) and high-byte enable, steers
// write bytes and gathers read bytes.
// Assumes the byte enables are never both zero.
module xbus_lanes #(
    parameter int unsigned ADDR_W = 26,
    parameter int unsigned CAS_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept_i,
    input  logic [ADDR_W-1:1] addr_i,
    input  logic [1:0]        be_i,
    input  logic [15:0]       wdata_i,
    input  logic              write_i,
    input  logic              io_i,
    input  logic              inta_i,
    input  logic [CAS_W-1:0]  cascade_i,
    input  logic              force16_i,
    input  logic              phase_i,
    input  logic              wide_i,
    input  logic              capture_i,
    output logic [ADDR_W-1:0] cyc_addr_o,
    output logic              bhe_n_o,
    output logic [15:0]       wlanes_o,
    output logic [15:0]       rdata_o,
    input  logic [15:0]       rlanes_i,
    output logic [1:0]        be_o,
    output logic              write_o,
    output logic              io_o,
    output logic              inta_o,
    output logic              force16_o
);

    localparam int unsigned CAS_LSB = ADDR_W - CAS_W;

    logic [ADDR_W-1:1] addr_q;
    logic [CAS_W-1:0]  cas_q;
    logic [15:0]       wdata_q;
    logic              odd_only;
    logic [ADDR_W-1:0] base;

    assign odd_only   = phase_i || (be_o == 2'b10);
    assign base       = {addr_q, odd_only};
    assign cyc_addr_o = inta_o ? {cas_q, base[CAS_LSB-1:0]} : base;
    assign bhe_n_o    = ~be_o[1];
    assign wlanes_o   = odd_only ? {wdata_q[15:8], wdata_q[15:8]} : wdata_q;

    // Hold the request fields for the whole access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q    <= '0;
            cas_q     <= '0;
            wdata_q   <= '0;
            be_o      <= 2'b01;
            write_o   <= 1'b0;
            io_o      <= 1'b0;
            inta_o    <= 1'b0;
            force16_o <= 1'b0;
        end else if (accept_i) begin
            addr_q    <= addr_i;
            cas_q     <= cascade_i;
            wdata_q   <= wdata_i;
            be_o      <= be_i;
            write_o   <= write_i;
            io_o      <= io_i;
            inta_o    <= inta_i;
            force16_o <= force16_i;
        end
    end

    // Gather read bytes into their request positions.
    always_ff @(posedge clk) begin
        if (!rst_n || accept_i) begin
            rdata_o <= '0;
        end else if (capture_i && !write_o) begin
            if (odd_only)
                rdata_o[15:8] <= wide_i ? rlanes_i[15:8] : rlanes_i[7:0];
            else if (wide_i)
                rdata_o <= {be_o[1] ? rlanes_i[15:8] : 8'h00, rlanes_i[7:0]};
            else
                rdata_o[7:0] <= rlanes_i[7:0];
        end
    end

    a_r3_second_half_odd: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_i && !inta_o) |-> (cyc_addr_o[0] && !bhe_n_o));

endmodule

// File: rtl/xbus_cycle_ctrl.sv
// External bus cycle controller top: joins the strap latch, the sequencer
// and the lane unit, and decodes command strobes and output enables.
// Assumes the external pins are resolved outside: each *_oe_o gates its
// matching *_o value.
module xbus_cycle_ctrl
    import xbus_pkg::*;
#(
    parameter int unsigned ADDR_W = 26,
    parameter int unsigned CAS_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid_i,
    output logic              req_ready_o,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [1:0]        req_be_i,
    input  logic              req_write_i,
    input  logic              req_io_i,
    input  logic              req_inta_i,
    input  logic [CAS_W-1:0]  req_cascade_i,
    input  logic              req_force16_i,
    input  logic [15:0]       req_wdata_i,
    output logic              done_o,
    output logic [15:0]       rdata_o,
    output logic [ADDR_W-1:0] bus_addr_o,
    output logic              bus_addr_oe_o,
    output logic              bus_bhe_n_o,
    output logic [15:0]       bus_data_o,
    input  logic [15:0]       bus_data_i,
    output logic              bus_data_oe_o,
    output logic              ior_n_o,
    output logic              iow_n_o,
    output logic              memr_n_o,
    output logic              memw_n_o,
    input  logic              cs16_n_i,
    output logic              cs16_n_o,
    output logic              cs16_oe_o,
    input  logic              rdy_i,
    input  logic              strap_a0_i,
    input  logic              strap_bhe_i,
    output logic              boot16_o,
    output logic              test_mode_o
);

    cyc_state_t          state;
    logic                phase, wide, accept, capture;
    logic [1:0]          be_q;
    logic                write_q, io_q, inta_q, force_q;
    logic                cmd_active;
    logic [1:0]          sel;
    logic [NUM_STB-1:0]  stb_n;

    xbus_strap u_strap (
        .clk         (clk),
        .rst_n       (rst_n),
        .pin_a0_i    (strap_a0_i),
        .pin_bhe_i   (strap_bhe_i),
        .boot16_o    (boot16_o),
        .test_mode_o (test_mode_o)
    );

    xbus_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid_i (req_valid_i),
        .test_mode_i (test_mode_o),
        .cs16_n_i    (cs16_n_i),
        .force16_i   (force_q),
        .be_i        (be_q),
        .rdy_i       (rdy_i),
        .state_o     (state),
        .phase_o     (phase),
        .wide_o      (wide),
        .req_ready_o (req_ready_o),
        .accept_o    (accept),
        .capture_o   (capture),
        .done_o      (done_o)
    );

    xbus_lanes #(.ADDR_W(ADDR_W), .CAS_W(CAS_W)) u_lanes (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept_i   (accept),
        .addr_i     (req_addr_i[ADDR_W-1:1]),
        .be_i       (req_be_i),
        .wdata_i    (req_wdata_i),
        .write_i    (req_write_i),
        .io_i       (req_io_i),
        .inta_i     (req_inta_i),
        .cascade_i  (req_cascade_i),
        .force16_i  (req_force16_i),
        .phase_i    (phase),
        .wide_i     (wide),
        .capture_i  (capture),
        .cyc_addr_o (bus_addr_o),
        .bhe_n_o    (bus_bhe_n_o),
        .wlanes_o   (bus_data_o),
        .rdata_o    (rdata_o),
        .rlanes_i   (bus_data_i),
        .be_o       (be_q),
        .write_o    (write_q),
        .io_o       (io_q),
        .inta_o     (inta_q),
        .force16_o  (force_q)
    );

    assign cmd_active = ((state == ST_CMD) || (state == ST_WAIT)) && !inta_q;
    assign sel        = stb_index(io_q, write_q);

    // One strobe per access kind, low only while the command phase runs.
    for (genvar k = 0; k < NUM_STB; k++) begin : g_stb
        assign stb_n[k] = ~(cmd_active && (sel == k[1:0]));
    end

    assign ior_n_o  = stb_n[0];
    assign iow_n_o  = stb_n[1];
    assign memr_n_o = stb_n[2];
    assign memw_n_o = stb_n[3];

    assign bus_addr_oe_o = !test_mode_o;
    assign bus_data_oe_o = write_q && (state != ST_IDLE) && !test_mode_o;
    assign cs16_n_o      = 1'b0;
    assign cs16_oe_o     = force_q && (state != ST_IDLE);

    a_r1_read_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (!ior_n_o || !memr_n_o) |-> !bus_data_oe_o);

    a_r9_test_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        test_mode_o |-> (!req_ready_o && !bus_addr_oe_o && !bus_data_oe_o && !done_o));

    a_r10_idle_release: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready_o |-> !bus_data_oe_o);

    a_r5_force_busy: assert property (@(posedge clk) disable iff (!rst_n)
        cs16_oe_o |-> !req_ready_o);

    a_r7_inta_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (inta_q && !req_ready_o) |-> (ior_n_o && iow_n_o && memr_n_o && memw_n_o));

endmodule

// File: tb/xbus_cycle_ctrl_test.sv
module xbus_cycle_ctrl_test;

    localparam int unsigned ADDR_W = 26;
    localparam int unsigned CAS_W  = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic              req_valid_i = 0, req_ready_o;
    logic [ADDR_W-1:0] req_addr_i = '0;
    logic [1:0]        req_be_i = 2'b01;
    logic              req_write_i = 0, req_io_i = 0, req_inta_i = 0, req_force16_i = 0;
    logic [CAS_W-1:0]  req_cascade_i = '0;
    logic [15:0]       req_wdata_i = '0;
    logic              done_o;
    logic [15:0]       rdata_o;
    logic [ADDR_W-1:0] bus_addr_o;
    logic              bus_addr_oe_o, bus_bhe_n_o, bus_data_oe_o;
    logic [15:0]       bus_data_o, bus_data_i;
    logic              ior_n_o, iow_n_o, memr_n_o, memw_n_o;
    logic              cs16_n_i, cs16_n_o, cs16_oe_o;
    logic              rdy_i = 1'b1;
    logic              strap_a0_i = 1'b1, strap_bhe_i = 1'b0;
    logic              boot16_o, test_mode_o;

    // Device model settings.
    logic dev16 = 1'b1;   // data width of the device
    logic fb_low = 1'b1;  // device pulls the width feedback low
    int   nwait = 0;
    int   wcnt = 0;

    int checks = 0;
    int failures = 0;

    xbus_cycle_ctrl #(.ADDR_W(ADDR_W), .CAS_W(CAS_W)) uut (.*);

    function automatic logic [7:0] dbyte(input logic [ADDR_W-1:0] a);
        return a[7:0] ^ 8'h5A;
    endfunction

    assign cs16_n_i   = ~fb_low;
    assign bus_data_i = dev16 ? {dbyte(bus_addr_o | 26'd1), dbyte(bus_addr_o & ~26'd1)}
                              : {8'hEE, dbyte(bus_addr_o)};

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    typedef struct {
        int                code;
        logic [ADDR_W-1:0] sa;
        logic              bhe_n;
        logic [15:0]       wd;
        int                lows;
        logic              cs16oe;
    } cyc_t;
    typedef struct {
        logic        is_rd;
        logic [15:0] rd;
    } res_t;

    cyc_t exp_cyc[$];
    res_t exp_res[$];

    // Ready model: holds ready low for nwait clocks of each command phase.
    always @(negedge clk) begin
        if (ior_n_o && iow_n_o && memr_n_o && memw_n_o) begin
            wcnt  = nwait;
            rdy_i = 1'b1;
        end else if (wcnt > 0) begin
            wcnt--;
            rdy_i = 1'b0;
        end else begin
            rdy_i = 1'b1;
        end
    end

    // Bus monitor: records each strobe pulse and compares it with the scoreboard.
    cyc_t obs;
    logic in_cyc = 1'b0;
    logic oe_seen;
    always @(negedge clk) begin
        int code;
        code = !ior_n_o ? 0 : !iow_n_o ? 1 : !memr_n_o ? 2 : !memw_n_o ? 3 : -1;
        if (code >= 0) begin
            if (!in_cyc) begin
                in_cyc     = 1'b1;
                obs.code   = code;
                obs.sa     = bus_addr_o;
                obs.bhe_n  = bus_bhe_n_o;
                obs.wd     = bus_data_o;
                obs.lows   = 1;
                obs.cs16oe = cs16_oe_o;
                oe_seen    = bus_data_oe_o;
            end else begin
                obs.lows++;
            end
        end else if (in_cyc) begin
            in_cyc = 1'b0;
            if (exp_cyc.size() == 0) begin
                chk(1'b0, "R1 unexpected strobe", obs.code, 32'hFFFF_FFFF);
            end else begin
                cyc_t e;
                e = exp_cyc.pop_front();
                chk(obs.code == e.code, "R1 strobe kind", obs.code, e.code);
                chk(obs.sa == e.sa, "R3 cycle address", obs.sa, e.sa);
                chk(obs.bhe_n == e.bhe_n, "R2 high byte enable", obs.bhe_n, e.bhe_n);
                chk(obs.lows == e.lows, "R6 strobe length", obs.lows, e.lows);
                chk(obs.cs16oe == e.cs16oe, "R5 width feedback drive", obs.cs16oe, e.cs16oe);
                if (e.code % 2 == 1) begin
                    chk(obs.wd == e.wd, "R3 write lanes", obs.wd, e.wd);
                    chk(oe_seen, "R10 data enable in write", oe_seen, 1);
                end else begin
                    chk(!oe_seen, "R10 no data enable in read", oe_seen, 0);
                end
            end
        end
    end

    // Result monitor: checks read data on each done pulse.
    always @(negedge clk) begin
        if (done_o) begin
            if (exp_res.size() == 0) begin
                chk(1'b0, "R11 unexpected done", 1, 0);
            end else begin
                res_t r;
                r = exp_res.pop_front();
                if (r.is_rd) chk(rdata_o == r.rd, "R11 read data", rdata_o, r.rd);
            end
        end
    end

    task automatic push_cyc(input int code, input logic [ADDR_W-1:0] sa, input logic bhe_n,
                            input logic [15:0] wd, input logic frc);
        cyc_t c;
        c.code = code; c.sa = sa; c.bhe_n = bhe_n; c.wd = wd;
        c.lows = 1 + nwait; c.cs16oe = frc;
        exp_cyc.push_back(c);
    endtask

    // Driver: computes the expected cycles and result, then runs the handshake.
    task automatic issue(input logic [ADDR_W-1:0] addr, input logic [1:0] be, input logic wr,
                         input logic io, input logic inta, input logic [CAS_W-1:0] cas,
                         input logic frc, input logic [15:0] wd);
        logic [ADDR_W-1:0] a;
        logic [15:0]       oddw;
        res_t              r;
        int                code;
        a    = {addr[ADDR_W-1:1], 1'b0};
        oddw = {wd[15:8], wd[15:8]};
        code = {30'd0, ~io, wr};
        if (!inta) begin
            if (fb_low || frc) begin
                push_cyc(code, (be == 2'b10) ? (a | 26'd1) : a, ~be[1], (be == 2'b10) ? oddw : wd, frc);
            end else if (be == 2'b11) begin
                push_cyc(code, a, 1'b0, wd, frc);
                push_cyc(code, a | 26'd1, 1'b0, oddw, frc);
            end else begin
                push_cyc(code, (be == 2'b10) ? (a | 26'd1) : a, ~be[1], (be == 2'b10) ? oddw : wd, frc);
            end
        end
        r.is_rd = !wr;
        r.rd    = {be[1] ? dbyte(a | 26'd1) : 8'h00, be[0] ? dbyte(a) : 8'h00};
        exp_res.push_back(r);

        @(negedge clk);
        req_addr_i = addr; req_be_i = be; req_write_i = wr; req_io_i = io;
        req_inta_i = inta; req_cascade_i = cas; req_force16_i = frc; req_wdata_i = wd;
        req_valid_i = 1'b1;
        while (!req_ready_o) @(negedge clk);
        @(negedge clk);
        req_valid_i = 1'b0;
        // Now in the first address phase.
        chk(!req_ready_o, "R12 busy after accept", req_ready_o, 0);
        if (inta) begin
            chk(bus_addr_o[25:23] == cas, "R7 cascade on address 25:23", bus_addr_o[25:23], cas);
            chk(bus_addr_o[22:1] == addr[22:1], "R7 lower address kept", bus_addr_o[22:1], addr[22:1]);
        end
        while (!done_o) begin
            if (inta) chk(ior_n_o && iow_n_o && memr_n_o && memw_n_o, "R7 no strobe", 
                          {ior_n_o, iow_n_o, memr_n_o, memw_n_o}, 4'hF);
            @(negedge clk);
        end
        @(negedge clk);
        chk(req_ready_o && !bus_data_oe_o, "R10 data released when idle",
            {req_ready_o, bus_data_oe_o}, 2'b10);
    endtask

    task automatic do_reset(input logic a0, input logic bhe);
        @(negedge clk);
        rst_n = 1'b0; strap_a0_i = a0; strap_bhe_i = bhe;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        strap_a0_i = ~a0; strap_bhe_i = ~bhe;   // later pin activity must not matter
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        do_reset(1'b1, 1'b0);
        // Reset state.
        chk(boot16_o == 1'b0, "R8 boot width strap", boot16_o, 0);
        chk(test_mode_o == 1'b0, "R8 run mode strap", test_mode_o, 0);
        chk(req_ready_o && !done_o && !bus_data_oe_o, "R12 idle after reset",
            {req_ready_o, done_o, bus_data_oe_o}, 3'b100);
        chk(ior_n_o && iow_n_o && memr_n_o && memw_n_o, "R1 strobes high after reset",
            {ior_n_o, iow_n_o, memr_n_o, memw_n_o}, 4'hF);

        // Word-wide device.
        dev16 = 1; fb_low = 1; nwait = 0;
        issue(26'h0001_230, 2'b11, 0, 0, 0, 3'd0, 0, 16'h0000);   // R4 memory word read
        nwait = 2;
        issue(26'h0000_3A4, 2'b11, 1, 1, 0, 3'd0, 0, 16'hBEEF);   // R6 io word write
        nwait = 0;
        issue(26'h0000_511, 2'b10, 1, 0, 0, 3'd0, 0, 16'hC37E);   // R2 odd byte memory write
        issue(26'h0000_620, 2'b01, 0, 1, 0, 3'd0, 0, 16'h0000);   // R11 even byte io read

        // Byte-wide device.
        dev16 = 0; fb_low = 0;
        issue(26'h0002_440, 2'b11, 0, 0, 0, 3'd0, 0, 16'h0000);   // R3 split read
        issue(26'h0000_0C8, 2'b11, 1, 1, 0, 3'd0, 0, 16'h1289);   // R3 split write
        issue(26'h0000_0D5, 2'b10, 0, 0, 0, 3'd0, 0, 16'h0000);   // R3 odd byte read on low lanes
        nwait = 3;
        issue(26'h0000_0E0, 2'b01, 0, 1, 0, 3'd0, 0, 16'h0000);   // R6 waits on byte device
        nwait = 0;

        // Forced width: word device that does not drive the feedback.
        dev16 = 1; fb_low = 0;
        issue(26'h0000_7B0, 2'b11, 0, 0, 0, 3'd0, 1, 16'h0000);   // R5 forced read
        issue(26'h0000_7C0, 2'b11, 1, 0, 0, 3'd0, 1, 16'h55AA);   // R5 forced write

        // Interrupt acknowledge.
        fb_low = 1;
        issue(26'h0000_234, 2'b01, 0, 0, 1, 3'b101, 0, 16'h0000); // R7 cascade code

        // Test tri-state mode via straps.
        do_reset(1'b0, 1'b1);
        chk(test_mode_o == 1'b1, "R8 test mode strap", test_mode_o, 1);
        chk(boot16_o == 1'b1, "R8 16-bit boot strap", boot16_o, 1);
        @(negedge clk);
        req_valid_i = 1'b1; req_be_i = 2'b11; req_write_i = 1'b1;
        repeat (8) begin
            @(negedge clk);
            chk(!req_ready_o && !bus_addr_oe_o && !bus_data_oe_o && !done_o, "R9 test mode quiet",
                {req_ready_o, bus_addr_oe_o, bus_data_oe_o, done_o}, 4'h0);
        end
        req_valid_i = 1'b0;

        // Back to normal running.
        do_reset(1'b1, 1'b0);
        chk(test_mode_o == 1'b0, "R8 run mode after second reset", test_mode_o, 0);
        issue(26'h0000_900, 2'b11, 0, 1, 0, 3'd0, 0, 16'h0000);   // R1 io read after test mode

        repeat (4) @(negedge clk);
        chk(exp_cyc.size() == 0, "R1 all bus cycles seen", exp_cyc.size(), 0);
        chk(exp_res.size() == 0, "R11 all results seen", exp_res.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule